// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter

This block keeps the time and date of a real-time clock: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. A single-cycle pulse on `tick_1hz` advances the time by one second, and carries ripple through minutes, hours and the calendar fields, with the month length and the leap year taken into account. Every time field is kept in either packed BCD or plain binary, chosen by a mode bit in the control byte. The hour follows either a 24-hour or a 12-hour format; in the 12-hour format the top bit of the hour byte is the afternoon flag.

The host reaches all 128 byte locations through a two-address port. A write to the even address selects a location, and the odd address then reads or writes that location. A halt bit in the control byte freezes the count so that software can load a new time without it moving underneath. Locations that hold neither time fields nor status bytes act as plain storage.

Top module: `rtc_calendar`

## Requirements
- R1: Bit 2 of the control byte at location 0x0B selects the encoding of every time field: 1 means plain binary, 0 means packed BCD with tens in bits 7..4 and units in bits 3..0. Counting follows the selected encoding.
- R2: Bit 1 of location 0x0B selects the 24-hour format (hour 0..23) when 1. When it is 0, the hour byte holds 1..12 in bits 6..0, midnight and noon both read as 12, and bit 7 is set for hours 12 through 23.
- R3: Each tick advances the fields at these locations: seconds 0x00 and minutes 0x02 (0..59), hours 0x04, day of week 0x06 (1..7), day of month 0x07, month 0x08 (1..12), year 0x09 (0..99) and century 0x32 (0..99). A field that passes its top value returns to its lowest value and carries one into the next field; an hour carry advances both day of week and day of month.
- R4: While bit 7 of location 0x0B is 1, ticks change no field. Once it returns to 0, counting continues from the values held at that point, including values written during the halt.
- R5: The day of month wraps after 30 days in months 4, 6, 9 and 11, after 31 days in the other months, and in month 2 after 29 days when the year field is divisible by 4 and after 28 days otherwise.
- R6: After reset, location 0x0A holds 0x26, 0x0B holds 0x02, 0x0C holds 0x00 and 0x0D holds 0x80. Day of week, day of month and month hold 1, all other locations hold 0, and the selected location is 0.
- R7: A host write to the even address (`io_odd` = 0) loads data bits 6..0 as the location and ignores bit 7. A write or read on the odd address reaches the selected location. A read of the even address returns 0xFF.
- R8: Locations 0x0C and 0x0D ignore host writes and keep their values.
- R9: Every location other than the time fields, 0x0C and 0x0D (including 0x0A and 0x0B) returns the last byte written to it.
- R10: When a host write and a counting tick land in the same cycle, the written byte wins at its own location, while the carry computed from the value held before that cycle still reaches the following fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-cycle pulse marking a one-second step |
| io_en | input | 1 | Host access in this cycle |
| io_we | input | 1 | Host access is a write |
| io_odd | input | 1 | 1 selects the data address, 0 selects the location address |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, combinational from the selected location |

## Verification
The hardest situation to reach from the ports is a carry that runs through every field at once: the last second of the year, the end of a century, or the end of February in and out of a leap year. Only one specific loaded time leads to each of these. The bench loads such times directly through the data port and then gives a single tick. It also draws random times with the seconds close to 59 in random encoding and hour modes, so that short bursts of ticks cross minute, hour and day borders. A tick and a write to the seconds location in the same cycle is driven on purpose to show that the write takes priority at its own location while the carry still propagates.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int BYTE_W = 8;
  localparam int VAL_W  = 7;

  // byte locations decoded by software
  localparam int LOC_SEC  = 0;
  localparam int LOC_MIN  = 2;
  localparam int LOC_HOUR = 4;
  localparam int LOC_DOW  = 6;
  localparam int LOC_DOM  = 7;
  localparam int LOC_MON  = 8;
  localparam int LOC_YEAR = 9;
  localparam int LOC_CTLA = 10;
  localparam int LOC_CTLB = 11;
  localparam int LOC_STAT = 12;
  localparam int LOC_FLAG = 13;
  localparam int LOC_CENT = 50;

  // control byte bit positions
  localparam int BIT_HALT = 7;
  localparam int BIT_BIN  = 2;
  localparam int BIT_H24  = 1;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [VAL_W-1:0]  val_t;

  function automatic val_t raw_to_val(byte_t raw, logic bin);
    if (bin) return raw[VAL_W-1:0];
    return val_t'(raw[7:4]) * val_t'(10) + val_t'(raw[3:0]);
  endfunction

  function automatic byte_t val_to_raw(val_t v, logic bin);
    val_t tens;
    val_t ones;
    tens = v / val_t'(10);
    ones = v % val_t'(10);
    if (bin) return {1'b0, v};
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic val_t month_len(val_t mon, val_t yr);
    case (mon)
      7'd2:                      return (yr[1:0] == 2'b00) ? val_t'(29) : val_t'(28);
      7'd4, 7'd6, 7'd9, 7'd11:   return val_t'(30);
      default:                   return val_t'(31);
    endcase
  endfunction

endpackage

// File: rtl/rtc_field_step.sv
module rtc_field_step
  import rtc_cal_pkg::*;
(
  input  byte_t cur,
  input  logic  bin_mode,
  input  logic  adv,
  input  val_t  lo,
  input  val_t  hi,
  output byte_t nxt,
  output logic  wrap
);

  val_t v;

  always_comb begin
    v    = raw_to_val(cur, bin_mode);
    nxt  = cur;
    wrap = 1'b0;
    if (adv) begin
      if (v >= hi) begin
        nxt  = val_to_raw(lo, bin_mode);
        wrap = 1'b1;
      end else begin
        nxt  = val_to_raw(v + val_t'(1), bin_mode);
      end
    end
  end

endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
  import rtc_cal_pkg::*;
(
  input  byte_t cur,
  input  logic  bin_mode,
  input  logic  h24,
  input  logic  adv,
  output byte_t nxt,
  output logic  wrap
);

  val_t low_part;
  val_t h;
  val_t hn;
  val_t h12;

  always_comb begin
    low_part = raw_to_val({1'b0, cur[6:0]}, bin_mode);
    if (h24) h = raw_to_val(cur, bin_mode);
    else     h = (low_part % val_t'(12)) + (cur[7] ? val_t'(12) : val_t'(0));

    wrap = adv && (h >= val_t'(23));
    hn   = (h >= val_t'(23)) ? val_t'(0) : h + val_t'(1);
    h12  = ((hn % val_t'(12)) == val_t'(0)) ? val_t'(12) : (hn % val_t'(12));

    if (!adv)     nxt = cur;
    else if (h24) nxt = val_to_raw(hn, bin_mode);
    else          nxt = val_to_raw(h12, bin_mode) | ((hn >= val_t'(12)) ? 8'h80 : 8'h00);
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       io_en,
  input  logic       io_we,
  input  logic       io_odd,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata
);

  localparam int DEPTH = 1 << IDX_W;

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  byte_t            mem   [DEPTH];
  byte_t            mem_d [DEPTH];
  logic [IDX_W-1:0] idx_q;

  logic bin_m, h24_m, halt, tick_go;
  logic data_wr, idx_wr, locked, mem_en;

  assign bin_m   = mem[LOC_CTLB][BIT_BIN];
  assign h24_m   = mem[LOC_CTLB][BIT_H24];
  assign halt    = mem[LOC_CTLB][BIT_HALT];
  assign tick_go = tick_1hz & ~halt;
  assign data_wr = io_en & io_we & io_odd;
  assign idx_wr  = io_en & io_we & ~io_odd;
  assign locked  = (idx_q == IDX_W'(LOC_STAT)) || (idx_q == IDX_W'(LOC_FLAG));
  assign mem_en  = tick_go | data_wr;

  // carry chain
  byte_t sec_n, min_n, hr_n, dow_n, dom_n, mon_n, yr_n, cen_n;
  logic  c_sec, c_min, c_hr, c_dow, c_dom, c_mon, c_yr, c_cen;
  val_t  mon_v, yr_v, dom_hi;

  assign mon_v  = raw_to_val(mem[LOC_MON], bin_m);
  assign yr_v   = raw_to_val(mem[LOC_YEAR], bin_m);
  assign dom_hi = month_len(mon_v, yr_v);

  rtc_field_step u_sec (.cur(mem[LOC_SEC]),  .bin_mode(bin_m), .adv(tick_go),
                        .lo(7'd0), .hi(7'd59), .nxt(sec_n), .wrap(c_sec));
  rtc_field_step u_min (.cur(mem[LOC_MIN]),  .bin_mode(bin_m), .adv(c_sec),
                        .lo(7'd0), .hi(7'd59), .nxt(min_n), .wrap(c_min));
  rtc_hour_step  u_hr  (.cur(mem[LOC_HOUR]), .bin_mode(bin_m), .h24(h24_m), .adv(c_min),
                        .nxt(hr_n), .wrap(c_hr));
  rtc_field_step u_dow (.cur(mem[LOC_DOW]),  .bin_mode(bin_m), .adv(c_hr),
                        .lo(7'd1), .hi(7'd7), .nxt(dow_n), .wrap(c_dow));
  rtc_field_step u_dom (.cur(mem[LOC_DOM]),  .bin_mode(bin_m), .adv(c_hr),
                        .lo(7'd1), .hi(dom_hi), .nxt(dom_n), .wrap(c_dom));
  rtc_field_step u_mon (.cur(mem[LOC_MON]),  .bin_mode(bin_m), .adv(c_dom),
                        .lo(7'd1), .hi(7'd12), .nxt(mon_n), .wrap(c_mon));
  rtc_field_step u_yr  (.cur(mem[LOC_YEAR]), .bin_mode(bin_m), .adv(c_mon),
                        .lo(7'd0), .hi(7'd99), .nxt(yr_n), .wrap(c_yr));
  rtc_field_step u_cen (.cur(mem[LOC_CENT]), .bin_mode(bin_m), .adv(c_yr),
                        .lo(7'd0), .hi(7'd99), .nxt(cen_n), .wrap(c_cen));

  function automatic byte_t boot_value(int loc);
    case (loc)
      LOC_CTLA:                  return 8'h26;
      LOC_CTLB:                  return 8'h02;
      LOC_FLAG:                  return 8'h80;
      LOC_DOW, LOC_DOM, LOC_MON: return 8'h01;
      default:                   return 8'h00;
    endcase
  endfunction

  // next state
  always_comb begin
    mem_d           = mem;
    mem_d[LOC_SEC]  = sec_n;
    mem_d[LOC_MIN]  = min_n;
    mem_d[LOC_HOUR] = hr_n;
    mem_d[LOC_DOW]  = dow_n;
    mem_d[LOC_DOM]  = dom_n;
    mem_d[LOC_MON]  = mon_n;
    mem_d[LOC_YEAR] = yr_n;
    mem_d[LOC_CENT] = cen_n;
    if (data_wr && !locked) mem_d[idx_q] = io_wdata;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      idx_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= boot_value(i);
    end else begin
      if (idx_wr) idx_q <= io_wdata[IDX_W-1:0];
      if (mem_en) mem <= mem_d;
    end
  end

  always_comb begin
    io_rdata = io_odd ? mem[idx_q] : 8'hFF;
  end

  // checks
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_q)
    (halt && !data_wr) |=> $stable(mem[LOC_SEC]) && $stable(mem[LOC_HOUR])); // R4

  AST_STAT_LOCKED: assert property (@(posedge clk) disable iff (!rst_q)
    (data_wr && idx_q == IDX_W'(LOC_STAT)) |=> $stable(mem[LOC_STAT])); // R8

  AST_FLAG_LOCKED: assert property (@(posedge clk) disable iff (!rst_q)
    (data_wr && idx_q == IDX_W'(LOC_FLAG)) |=> $stable(mem[LOC_FLAG])); // R8

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_q)
    (tick_go && !data_wr && raw_to_val(mem[LOC_SEC], bin_m) == 7'd59)
      |=> (mem[LOC_SEC] == 8'h00) && !$stable(mem[LOC_MIN])); // R3

  AST_HOUR12_NONZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (tick_go && !data_wr && !h24_m && mem[LOC_HOUR][6:0] != 7'd0)
      |=> mem[LOC_HOUR][6:0] != 7'd0); // R2

  AST_DOM_RANGE: assert property (@(posedge clk) disable iff (!rst_q)
    (tick_go && !data_wr && raw_to_val(mem[LOC_DOM], bin_m) >= 7'd1 &&
     raw_to_val(mem[LOC_DOM], bin_m) <= dom_hi)
      |=> raw_to_val(mem[LOC_DOM], bin_m) >= 7'd1 &&
          raw_to_val(mem[LOC_DOM], bin_m) <= 7'd31); // R5

endmodule

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       io_en = 1'b0;
  logic       io_we = 1'b0;
  logic       io_odd = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;

  always #10 clk = ~clk;

  rtc_calendar u_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .io_en(io_en), .io_we(io_we), .io_odd(io_odd),
    .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model, binary values
  int m_sec, m_min, m_hr, m_dow, m_dom, m_mon, m_yr, m_cen;
  bit m_bin, m_h24, m_halt;

  function automatic int enc(int v, bit bin);
    if (bin) return v;
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int enc_hour(int h, bit bin, bit h24);
    int t;
    if (h24) return enc(h, bin);
    t = (h % 12 == 0) ? 12 : h % 12;
    return enc(t, bin) | ((h >= 12) ? 8'h80 : 0);
  endfunction

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_dow = (m_dow == 7) ? 1 : m_dow + 1;
          m_dom++;
          if (m_dom > mdays(m_mon, m_yr)) begin
            m_dom = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_yr++;
              if (m_yr == 100) begin m_yr = 0; m_cen = (m_cen + 1) % 100; end
            end
          end
        end
      end
    end
  endtask

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic bus(bit odd, logic [7:0] d);
    @(negedge clk);
    io_en = 1'b1; io_we = 1'b1; io_odd = odd; io_wdata = d;
    @(negedge clk);
    io_en = 1'b0; io_we = 1'b0;
  endtask

  task automatic wr(int loc, int val);
    bus(1'b0, 8'(loc));
    bus(1'b1, 8'(val));
  endtask

  task automatic rd(int loc, output int v);
    bus(1'b0, 8'(loc));
    io_en = 1'b1; io_we = 1'b0; io_odd = 1'b1;
    #1;
    v = int'(io_rdata);
    io_en = 1'b0;
  endtask

  task automatic set_mode(bit bin, bit h24, bit halt);
    m_bin = bin; m_h24 = h24; m_halt = halt;
    wr(11, (int'(halt) << 7) | (int'(bin) << 2) | (int'(h24) << 1));
  endtask

  task automatic load_time();
    wr(0, enc(m_sec, m_bin));
    wr(2, enc(m_min, m_bin));
    wr(4, enc_hour(m_hr, m_bin, m_h24));
    wr(6, enc(m_dow, m_bin));
    wr(7, enc(m_dom, m_bin));
    wr(8, enc(m_mon, m_bin));
    wr(9, enc(m_yr, m_bin));
    wr(50, enc(m_cen, m_bin));
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      if (!m_halt) model_step();
    end
  endtask

  task automatic verify(string tag);
    int v;
    rd(0, v);  check({tag, " sec"}, v, enc(m_sec, m_bin));
    rd(2, v);  check({tag, " min"}, v, enc(m_min, m_bin));
    rd(4, v);  check({tag, " hour"}, v, enc_hour(m_hr, m_bin, m_h24));
    rd(6, v);  check({tag, " dow"}, v, enc(m_dow, m_bin));
    rd(7, v);  check({tag, " dom"}, v, enc(m_dom, m_bin));
    rd(8, v);  check({tag, " mon"}, v, enc(m_mon, m_bin));
    rd(9, v);  check({tag, " year"}, v, enc(m_yr, m_bin));
    rd(50, v); check({tag, " cent"}, v, enc(m_cen, m_bin));
  endtask

  task automatic set_model(int s, int mi, int h, int dw, int dm, int mo, int y, int c);
    m_sec = s; m_min = mi; m_hr = h; m_dow = dw; m_dom = dm; m_mon = mo; m_yr = y; m_cen = c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset state
    rd(10, v); check("R6 ctl A", v, 8'h26);
    rd(11, v); check("R6 ctl B", v, 8'h02);
    rd(12, v); check("R6 stat", v, 8'h00);
    rd(13, v); check("R6 flag", v, 8'h80);
    set_model(0, 0, 0, 1, 1, 1, 0, 0); m_bin = 0; m_h24 = 1; m_halt = 0;
    verify("R6 boot");

    // R7 even read and index bit 7 ignored
    @(negedge clk); io_en = 1'b1; io_we = 1'b0; io_odd = 1'b0; #1;
    check("R7 even read", int'(io_rdata), 8'hFF);
    io_en = 1'b0;
    bus(1'b0, 8'hA0); bus(1'b1, 8'h5A);
    rd(8'h20, v); check("R7 index bit7 dropped", v, 8'h5A);

    // R9 plain storage
    wr(8'h45, 8'hC3); rd(8'h45, v); check("R9 spare byte", v, 8'hC3);
    wr(10, 8'h2F); rd(10, v); check("R9 ctl A storage", v, 8'h2F);
    wr(3, 8'h77); rd(3, v); check("R9 alarm slot", v, 8'h77);

    // R8 locked locations
    wr(12, 8'hFF); rd(12, v); check("R8 stat ignored", v, 8'h00);
    wr(13, 8'h00); rd(13, v); check("R8 flag ignored", v, 8'h80);

    // R3 R1 full carry in BCD, 24h, end of century
    set_mode(0, 1, 0);
    set_model(59, 59, 23, 7, 31, 12, 99, 19); load_time();
    pulse(1); verify("R3 century roll BCD");
    rd(50, v); check("R1 BCD century", v, 8'h20);

    // R5 leap years and month lengths, binary
    set_mode(1, 1, 0);
    set_model(59, 59, 23, 3, 28, 2, 24, 20); load_time();
    pulse(1); verify("R5 feb28 leap");
    set_model(59, 59, 23, 4, 29, 2, 24, 20); load_time();
    pulse(1); verify("R5 feb29 leap");
    set_model(59, 59, 23, 2, 28, 2, 23, 20); load_time();
    pulse(1); verify("R5 feb28 common");
    set_model(59, 59, 23, 5, 30, 4, 23, 20); load_time();
    pulse(1); verify("R5 apr30");
    rd(8, v); check("R1 binary month", v, 8'h05);

    // R2 12-hour format
    set_mode(1, 0, 0);
    set_model(59, 59, 11, 1, 10, 6, 30, 20); load_time();
    pulse(1); rd(4, v); check("R2 noon binary", v, 8'h8C);
    set_model(59, 59, 12, 1, 10, 6, 30, 20); load_time();
    pulse(1); rd(4, v); check("R2 one pm binary", v, 8'h81);
    set_mode(0, 0, 0);
    set_model(59, 59, 23, 1, 10, 6, 30, 20); load_time();
    pulse(1); rd(4, v); check("R2 midnight BCD", v, 8'h12);
    verify("R2 midnight day");

    // R4 halt then resume from written values
    set_mode(0, 1, 1);
    set_model(58, 59, 9, 2, 14, 3, 25, 20); load_time();
    pulse(3); verify("R4 halted");
    set_mode(0, 1, 0);
    pulse(2); verify("R4 resumed");

    // R10 write and tick in the same cycle
    set_model(59, 10, 8, 2, 14, 3, 25, 20); load_time();
    bus(1'b0, 8'h00);
    @(negedge clk);
    io_en = 1'b1; io_we = 1'b1; io_odd = 1'b1; io_wdata = 8'h30; tick_1hz = 1'b1;
    @(negedge clk);
    io_en = 1'b0; io_we = 1'b0; tick_1hz = 1'b0;
    rd(0, v); check("R10 write wins", v, 8'h30);
    rd(2, v); check("R10 carry kept", v, 8'h11);

    // random times near minute borders
    for (int it = 0; it < 30; it++) begin
      int mo, yr;
      set_mode(1'($urandom % 2), 1'($urandom % 2), 0);
      mo = 1 + $urandom % 12; yr = $urandom % 100;
      set_model(50 + $urandom % 10, ($urandom % 3 == 0) ? 59 : $urandom % 60,
                ($urandom % 3 == 0) ? 23 : $urandom % 24, 1 + $urandom % 7,
                ($urandom % 2 == 0) ? mdays(mo, yr) : 1 + $urandom % mdays(mo, yr),
                mo, yr, $urandom % 100);
      load_time();
      pulse(1 + $urandom % 12);
      verify("R3 R1 R2 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule